// File: doc/BRIEF.md
# Periodic Self-Test Scheduler

This block decides which measurement cycle of a cell-monitoring sequencer is turned into a self-test cycle. It then walks a fixed order of built-in checks during that cycle. A self-test is requested in one of two ways:
- an outside agent pulls a shared, pulled-up request line low;
- no self-test has completed for a long run of ordinary measurement cycles.

Either way, the cycle in progress always finishes first, and the next cycle the sequencer starts becomes the self-test. While the test runs, the block pulls the request line low itself so that the outside world can see the test. Its own pull is never taken as a fresh request.

The check results come in from the analog side as test inputs, one strobe per step:
- three comparator window outcomes;
- two conversion words;
- a channel-skip flag, sampled when the self-test cycle ends.

A sticky result flag reports the outcome of the most recent self-test. A failed result never stops the ordinary monitoring cycles. During the self-test cycle, undervoltage evaluation of cell channels is masked and only overvoltage stays active.

Top module: `selftest_sched`

## Requirements
- R1: A high-to-low transition seen on `req_line_i` while no self-test is running does not alter the cycle in progress. The next `cyc_start_i` pulse after the transition begins a self-test, and `st_active_o` is high from the clock after that pulse.
- R2: If no self-test completes for CYCLE_LIMIT (default 1024) consecutive ordinary cycles, the following `cyc_start_i` begins a self-test automatically. An ordinary cycle is counted by its `cyc_done_i` pulse.
- R3: `req_pull_o` is high exactly while a self-test runs. The low level this drive causes on the request line never schedules a further self-test.
- R4: `result_o` is 1 after reset. It changes only on the `cyc_done_i` pulse that ends a self-test: it becomes 1 if that test passed and 0 if it failed, and holds that value until the next test ends.
- R5: The comparator steps must report, in order: `cmp_res_i` = 2'b00 (inside the window), then 2'b01 (above the upper limit), then 2'b10 (below the lower limit). Any other code at a step fails the test.
- R6: The two conversion steps must report the alternating words with bit 0 set (0x555 for 12 bits) and then with bit 0 clear (0xAAA). Any other word fails the test.
- R7: A test fails if `chan_skip_i` is high on its ending `cyc_done_i`, or if fewer than five step strobes arrived before the cycle ended.
- R8: `uv_mask_o` is high during the self-test cycle and low during ordinary cycles.
- R9: `step_o` reads 0 when idle, 1 through 5 for the window, above, below, first-pattern and second-pattern steps, and 6 when all steps are done. Each `chk_stb_i` advances it by one, and it returns to 0 when the test ends.
- R10: The ordinary-cycle count restarts from zero whenever a self-test completes, whether that test was requested from outside or started by the count.
- R11: After a failing test, later ordinary cycles still run with `st_active_o` and `uv_mask_o` low, and new self-test requests are still served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_line_i | input | 1 | Sampled level of the shared request line |
| cyc_start_i | input | 1 | Sequencer strobe: a measurement cycle begins |
| cyc_done_i | input | 1 | Sequencer strobe: the current cycle ends |
| chk_stb_i | input | 1 | The result of one check step is presented |
| cmp_res_i | input | 2 | Comparator outcome: 00 inside, 01 above, 10 below |
| adc_word_i | input | ADC_W | Conversion word for a pattern step |
| chan_skip_i | input | 1 | A requested channel was skipped in this cycle |
| st_active_o | output | 1 | Self-test cycle in progress |
| req_pull_o | output | 1 | Drive that pulls the request line low |
| uv_mask_o | output | 1 | Undervoltage evaluation masked |
| step_o | output | 3 | Current check step |
| result_o | output | 1 | Sticky outcome of the last self-test |

## Verification
Each state change is due one clock after the input edge that causes it:
- `st_active_o`, `req_pull_o`, `uv_mask_o` and `step_o` settle one clock after the `cyc_start_i` or `chk_stb_i` strobe that moves them;
- `result_o` settles one clock after the ending `cyc_done_i`;
- a falling request edge only arms the next cycle start.

The bench drives inputs on falling clock edges. At each rising edge it steps a behavioural model, and it compares on the next falling edge, so every expected value is read exactly one register stage after its cause. The targeted checks sample in the same way, just after the strobe that matters.

// File: rtl/selftest_sched_pkg.sv
// Shared types for the self-test scheduler: step encoding and comparator codes.
package selftest_sched_pkg;

    typedef enum logic [2:0] {
        STP_IDLE  = 3'd0,
        STP_WIN   = 3'd1,
        STP_HI    = 3'd2,
        STP_LO    = 3'd3,
        STP_PAT_A = 3'd4,
        STP_PAT_B = 3'd5,
        STP_WAIT  = 3'd6
    } st_step_e;

    localparam logic [1:0] CMP_INSIDE = 2'b00;
    localparam logic [1:0] CMP_ABOVE  = 2'b01;
    localparam logic [1:0] CMP_BELOW  = 2'b10;

endpackage

// File: rtl/st_trigger.sv
// Trigger unit: detects an outside falling edge on the request line and
// counts ordinary cycles. It arms a pending request from either source and
// holds the active flag from the cycle start that consumes the request to
// the cycle end.
// Assumes cyc_start_i and cyc_done_i are single-clock pulses that alternate.
// Assumes CYCLE_LIMIT >= 2.
module st_trigger #(
    parameter int CYCLE_LIMIT = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_line_i,
    input  logic cyc_start_i,
    input  logic cyc_done_i,
    output logic active_o,
    output logic begin_o,
    output logic end_o
);
    localparam int CW = $clog2(CYCLE_LIMIT);
    localparam logic [CW-1:0] CNT_LAST = CW'(CYCLE_LIMIT - 1);

    logic          line_prev_q;
    logic          pend_q;
    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic          ext_fall;
    logic          wd_hit;
    logic          plain_done;

    // An edge while the test runs comes from the block's own pull; ignore it.
    assign ext_fall   = line_prev_q & ~req_line_i & ~active_q;
    assign plain_done = cyc_done_i & ~active_q & ~pend_q;
    assign wd_hit     = plain_done & (cnt_q == CNT_LAST);
    assign begin_o    = cyc_start_i & pend_q & ~active_q;
    assign end_o      = cyc_done_i & active_q;
    assign active_o   = active_q;

    // Remembers the line level for edge detection; the line idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) line_prev_q <= 1'b1;
        else        line_prev_q <= req_line_i;
    end

    // Arms a request from either source; a consumed request is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q & ~begin_o) | ext_fall | wd_hit;
    end

    // Counts ordinary cycles; cleared by any completed self-test.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt_q <= '0;
        else if (end_o)                       cnt_q <= '0;
        else if (plain_done && !wd_hit)       cnt_q <= cnt_q + 1'b1;
    end

    // Self-test window: from the consuming start to the next cycle end.
    always_ff @(posedge clk) begin
        if (!rst_n)       active_q <= 1'b0;
        else if (begin_o) active_q <= 1'b1;
        else if (end_o)   active_q <= 1'b0;
    end

    // R1: a test only starts from an armed request.
    p_start_needs_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> $past(pend_q));

    // R3: while the test runs, the request and the cycle count stay frozen.
    p_frozen_while_test_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && !cyc_done_i) |=> ($stable(pend_q) && $stable(cnt_q)));

    // R10: a completed test leaves the count at zero.
    p_count_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        end_o |=> (cnt_q == '0));
endmodule

// File: rtl/st_check_seq.sv
// Check sequencer: walks the window, above, below, pattern A and pattern B
// steps on each strobe and accumulates any mismatch. On the cycle end it
// folds in the skip flag and completeness into the sticky result.
// Assumes begin_i and end_i come from the trigger unit and never coincide.
module st_check_seq
    import selftest_sched_pkg::*;
#(
    parameter int ADC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             begin_i,
    input  logic             end_i,
    input  logic             chk_stb_i,
    input  logic [1:0]       cmp_res_i,
    input  logic [ADC_W-1:0] adc_word_i,
    input  logic             chan_skip_i,
    output st_step_e         step_o,
    output logic             result_o
);
    logic [ADC_W-1:0] pat_a;
    logic [ADC_W-1:0] pat_b;
    st_step_e         step_q;
    logic             fail_q;
    logic             result_q;
    logic             step_bad;
    logic             in_steps;

    // Alternating words: pattern A has the even bits set, B is its complement.
    for (genvar b = 0; b < ADC_W; b++) begin : g_pat
        assign pat_a[b] = ((b % 2) == 0);
        assign pat_b[b] = ((b % 2) != 0);
    end

    assign in_steps = (step_q != STP_IDLE) && (step_q != STP_WAIT);

    // Mismatch of the presented result against the current step's expectation.
    always_comb begin
        case (step_q)
            STP_WIN:   step_bad = (cmp_res_i != CMP_INSIDE);
            STP_HI:    step_bad = (cmp_res_i != CMP_ABOVE);
            STP_LO:    step_bad = (cmp_res_i != CMP_BELOW);
            STP_PAT_A: step_bad = (adc_word_i != pat_a);
            STP_PAT_B: step_bad = (adc_word_i != pat_b);
            default:   step_bad = 1'b0;
        endcase
    end

    // Step register, failure accumulator and sticky result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q   <= STP_IDLE;
            fail_q   <= 1'b0;
            result_q <= 1'b1;
        end else if (end_i) begin
            result_q <= ~(fail_q | (step_q != STP_WAIT) | chan_skip_i);
            step_q   <= STP_IDLE;
            fail_q   <= 1'b0;
        end else if (begin_i) begin
            step_q <= STP_WIN;
            fail_q <= 1'b0;
        end else if (chk_stb_i && in_steps) begin
            step_q <= st_step_e'(step_q + 3'd1);
            fail_q <= fail_q | step_bad;
        end
    end

    assign step_o   = step_q;
    assign result_o = result_q;

    // R4: the result only moves on the end of a self-test.
    p_result_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !end_i |=> $stable(result_q));

    // R7: an unfinished step walk always reports failure.
    p_incomplete_fails_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (end_i && step_q != STP_WAIT) |=> !result_q);
endmodule

// File: rtl/selftest_sched.sv
// Self-test scheduler top: ties the trigger unit to the check sequencer and
// brings out the active flag, the request-line pull, the undervoltage mask,
// the step and the sticky result.
// Assumes the request line is sampled synchronously outside this block.
module selftest_sched
    import selftest_sched_pkg::*;
#(
    parameter int CYCLE_LIMIT = 1024,
    parameter int ADC_W       = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_line_i,
    input  logic             cyc_start_i,
    input  logic             cyc_done_i,
    input  logic             chk_stb_i,
    input  logic [1:0]       cmp_res_i,
    input  logic [ADC_W-1:0] adc_word_i,
    input  logic             chan_skip_i,
    output logic             st_active_o,
    output logic             req_pull_o,
    output logic             uv_mask_o,
    output logic [2:0]       step_o,
    output logic             result_o
);
    logic     active;
    logic     test_begin;
    logic     test_end;
    st_step_e step;

    st_trigger #(.CYCLE_LIMIT(CYCLE_LIMIT)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_line_i (req_line_i),
        .cyc_start_i(cyc_start_i),
        .cyc_done_i (cyc_done_i),
        .active_o   (active),
        .begin_o    (test_begin),
        .end_o      (test_end)
    );

    st_check_seq #(.ADC_W(ADC_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .begin_i    (test_begin),
        .end_i      (test_end),
        .chk_stb_i  (chk_stb_i),
        .cmp_res_i  (cmp_res_i),
        .adc_word_i (adc_word_i),
        .chan_skip_i(chan_skip_i),
        .step_o     (step),
        .result_o   (result_o)
    );

    assign st_active_o = active;
    assign req_pull_o  = active;
    assign uv_mask_o   = active;
    assign step_o      = step;

    // R9: the step is non-idle exactly while the trigger unit holds a test.
    p_step_tracks_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
        active == (step != STP_IDLE));
endmodule

// File: tb/selftest_sched_tb.sv
`timescale 1ns/1ps
module selftest_sched_tb;
    localparam int LIMIT = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_pull = 1'b0;
    logic        cyc_start = 1'b0, cyc_done = 1'b0, stb = 1'b0, skip_in = 1'b0;
    logic [1:0]  cmp = 2'b00;
    logic [11:0] adc = 12'h000;
    logic        st_active, req_pull, uv_mask, result;
    logic [2:0]  step;
    wire         req_line = ~(ext_pull | req_pull);

    int n_chk = 0, n_bad = 0, n_clk = 0;
    bit done_flag = 0;

    // Behavioural model state
    int m_cnt, m_step;
    bit m_act, m_pend, m_prev, m_res, m_fail;

    always #2.5 clk = ~clk;

    selftest_sched u_dut (
        .clk(clk), .rst_n(rst_n), .req_line_i(req_line),
        .cyc_start_i(cyc_start), .cyc_done_i(cyc_done), .chk_stb_i(stb),
        .cmp_res_i(cmp), .adc_word_i(adc), .chan_skip_i(skip_in),
        .st_active_o(st_active), .req_pull_o(req_pull), .uv_mask_o(uv_mask),
        .step_o(step), .result_o(result)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // Model advanced on each rising edge from the inputs held since the falling edge.
    always @(posedge clk) begin : model
        bit line, bgn, fin, fall, hit, bad;
        if (!rst_n) begin
            m_cnt = 0; m_act = 0; m_pend = 0; m_prev = 1;
            m_res = 1; m_fail = 0; m_step = 0;
        end else begin
            line = !(ext_pull || m_act);
            bgn  = cyc_start && m_pend && !m_act;
            fin  = cyc_done && m_act;
            fall = m_prev && !line && !m_act;
            hit  = cyc_done && !m_act && !m_pend && (m_cnt == LIMIT - 1);
            case (m_step)
                1: bad = (cmp != 2'b00);
                2: bad = (cmp != 2'b01);
                3: bad = (cmp != 2'b10);
                4: bad = (adc != 12'h555);
                5: bad = (adc != 12'hAAA);
                default: bad = 0;
            endcase
            if (fin) begin
                m_res = !(m_fail || m_step != 6 || skip_in);
                m_fail = 0; m_step = 0;
            end else if (bgn) begin
                m_step = 1; m_fail = 0;
            end else if (stb && m_step >= 1 && m_step <= 5) begin
                m_fail = m_fail || bad; m_step++;
            end
            if (fin) m_cnt = 0;
            else if (cyc_done && !m_act && !m_pend && m_cnt < LIMIT - 1) m_cnt++;
            m_pend = (m_pend && !bgn) || fall || hit;
            if (bgn) m_act = 1; else if (fin) m_act = 0;
            m_prev = line;
        end
    end

    // Compare every clock, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            chk("R1 active vs model", st_active, m_act);
            chk("R3 pull vs model", req_pull, m_act);
            chk("R8 mask vs model", uv_mask, m_act);
            chk("R9 step vs model", step, m_step);
            chk("R4 result vs model", result, m_res);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        n_clk++;
        if (n_clk > 150000 && !done_flag) begin
            done_flag = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%0d exp=0", n_clk);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic plain_cycle(input bit pull_mid);
        @(negedge clk) cyc_start = 1;
        @(negedge clk) cyc_start = 0;
        if (pull_mid) ext_pull = 1;
        @(negedge clk) ext_pull = 0;
        cyc_done = 1;
        @(negedge clk) cyc_done = 0;
    endtask

    task automatic ext_request();
        @(negedge clk) ext_pull = 1;
        @(negedge clk) ext_pull = 0;
    endtask

    task automatic run_test(input string tag, input logic [1:0] c0, c1, c2,
                            input logic [11:0] a0, a1, input int nstb, input bit skip);
        @(negedge clk) cyc_start = 1;
        @(negedge clk) cyc_start = 0;
        chk(tag, st_active, 1);
        chk("R3 pull during test", req_pull, 1);
        chk("R8 mask during test", uv_mask, 1);
        for (int k = 0; k < nstb; k++) begin
            stb = 1;
            cmp = (k == 0) ? c0 : (k == 1) ? c1 : c2;
            adc = (k == 3) ? a0 : a1;
            @(negedge clk);
        end
        stb = 0;
        cyc_done = 1; skip_in = skip;
        @(negedge clk) cyc_done = 0; skip_in = 0;
    endtask

    initial begin
        int miss;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R4 result after reset", result, 1);
        chk("R9 step after reset", step, 0);
        chk("R3 pull after reset", req_pull, 0);

        plain_cycle(0);
        plain_cycle(1);                       // R1: outside edge mid-cycle
        chk("R1 cycle in progress untouched", st_active, 0);
        run_test("R1 next start is self-test", 2'b00, 2'b01, 2'b10, 12'h555, 12'hAAA, 5, 0);
        chk("R4 pass result", result, 1);
        chk("R9 step back to idle", step, 0);
        plain_cycle(0);
        chk("R3 own pull not a new request", st_active, 0);

        ext_request();
        run_test("R1 start after edge", 2'b01, 2'b00, 2'b10, 12'h555, 12'hAAA, 5, 0);
        chk("R5 wrong comparator order fails", result, 0);
        plain_cycle(0);
        chk("R11 monitoring after fail", st_active, 0);
        chk("R11 mask low after fail", uv_mask, 0);
        chk("R4 result held low", result, 0);

        ext_request();
        run_test("R11 request served after fail", 2'b00, 2'b01, 2'b10, 12'h555, 12'hAAA, 5, 0);
        chk("R4 later pass restores", result, 1);

        ext_request();
        run_test("R1 start", 2'b00, 2'b01, 2'b10, 12'h554, 12'hAAA, 5, 0);
        chk("R6 bad first pattern fails", result, 0);
        ext_request();
        run_test("R1 start", 2'b00, 2'b01, 2'b10, 12'hAAA, 12'h555, 5, 0);
        chk("R6 swapped patterns fail", result, 0);
        ext_request();
        run_test("R1 start", 2'b00, 2'b01, 2'b11, 12'h555, 12'hAAA, 5, 0);
        chk("R5 bad below code fails", result, 0);
        ext_request();
        run_test("R1 start", 2'b00, 2'b01, 2'b10, 12'h555, 12'hAAA, 5, 1);
        chk("R7 skipped channel fails", result, 0);
        ext_request();
        run_test("R1 start", 2'b00, 2'b01, 2'b10, 12'h555, 12'hAAA, 3, 0);
        chk("R7 incomplete walk fails", result, 0);

        // R10 then R2: count restarts at the outside-triggered test above.
        repeat (600) plain_cycle(0);
        ext_request();
        run_test("R10 outside test", 2'b00, 2'b01, 2'b10, 12'h555, 12'hAAA, 5, 0);
        chk("R10 pass", result, 1);
        miss = 0;
        for (int i = 0; i < LIMIT; i++) begin
            @(negedge clk) cyc_start = 1;
            @(negedge clk) cyc_start = 0;
            if (st_active) miss++;
            cyc_done = 1;
            @(negedge clk) cyc_done = 0;
        end
        chk("R10 no early automatic test", miss, 0);
        run_test("R2 automatic test after limit", 2'b00, 2'b01, 2'b10, 12'h555, 12'hAAA, 5, 0);
        chk("R2 automatic pass", result, 1);
        plain_cycle(0);
        chk("R2 no repeat after automatic test", st_active, 0);

        repeat (2) @(negedge clk);
        done_flag = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule